// File: doc/BRIEF.md
# Up/down tenths-resolution seconds timer

This block is a three-digit decimal timer that shows elapsed time from 00.0 to 59.9 seconds in steps of one tenth of a second. A free-running divider turns the system clock into a one-cycle step enable every tenth of a second. Three BCD digit registers follow that enable: a tenths digit, a seconds-ones digit and a seconds-tens digit. Each digit passes a carry or a borrow to the digit above it. A seven-segment decoder drives one active-low segment output per digit.

A direction input chooses whether the timer counts up or down. It never stops at either end: it wraps from 59.9 to 00.0 going up, and from 00.0 to 59.9 going down. A run/hold switch freezes the count while the digits stay lit. An active-low preset pushbutton loads 59.9. The preset is synchronised inside the block and acts once for each press. All registers run on the system clock. The divided tick is only an enable, never a clock.

Top module: `updown_tenths_timer`

## Requirements
- R1: While `rst_n` is low, and right after it goes low (asynchronously), the count is 00.0. All three segment outputs then show the code for 0 (0x40).
- R2: With `run` high and counting up, the count advances by one tenth once every `CLK_DIV` clock cycles. The first step happens on the `CLK_DIV`-th rising edge after reset is released, and the count is unchanged on the edges before it.
- R3: Counting up, the tenths digit carries into seconds-ones on its 9→0 step, and seconds-ones carries into seconds-tens on its 9→0 step. The step after 59.9 gives 00.0.
- R4: Counting down, the digits borrow in the same order. A tenths or ones digit wraps 0→9, and the tens digit wraps 0→5, so the step after 00.0 gives 59.9 and the step after 10.0 gives 09.9.
- R5: A change of `count_up` between steps takes effect on the next step, with no extra step and no skipped value.
- R6: The preset is acted on at a falling edge of the active-low `preset_n`, after a two-flop synchroniser. The count becomes 59.9 on the third rising edge that samples `preset_n` low. Keeping the button held down does not load again, and counting goes on from 59.9.
- R7: When a preset load and a count step fall on the same clock edge, the preset wins and the count is 59.9 after that edge.
- R8: With `run` low the count does not change, and the segment outputs keep showing the held value. A preset press still loads 59.9 while in hold. Raising `run` again resumes counting from the held value.
- R9: Each segment output is active-low, with bit 0 = segment a through bit 6 = segment g. Digit codes: 0=0x40, 1=0x79, 2=0x24, 3=0x30, 4=0x19, 5=0x12, 6=0x02, 7=0x78, 8=0x00, 9=0x18. `seg_tenths` shows tenths, `seg_sec_ones` shows seconds ones and `seg_sec_tens` shows seconds tens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_up | input | 1 | 1 = count up, 0 = count down |
| preset_n | input | 1 | Active-low preset pushbutton, asynchronous to clk |
| run | input | 1 | 1 = run, 0 = hold |
| seg_tenths | output | 7 | Active-low segments, tenths digit |
| seg_sec_ones | output | 7 | Active-low segments, seconds ones digit |
| seg_sec_tens | output | 7 | Active-low segments, seconds tens digit |

## Verification
The bench builds the timer with `CLK_DIV` = 4, a two-stage synchroniser and active-low segments. With four clocks per tenth, the full 600-step cycle in both directions, and both the 59.9→00.0 and 10.0→09.9 transitions, fit in a few thousand cycles. The short divider also lets the bench place a preset press so that its load edge lands exactly on a step edge, which checks the priority rule. The default 50 MHz divide ratio is covered only by elaboration.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int DIGITS = 3;
   localparam int BCD_W  = 4;
   localparam int SEG_W  = 7;

   typedef logic [BCD_W-1:0] bcd_t;
   typedef logic [SEG_W-1:0] seg_t;

   // Highest value of each digit: tenths and seconds ones reach 9, seconds tens reaches 5.
   function automatic int digit_limit(input int idx);
      return (idx == DIGITS-1) ? 5 : 9;
   endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int DIV = 5_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("tmr_tick_gen: DIV must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_q == LAST)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/tmr_press_sync.sv
module tmr_press_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_n,
   output logic press_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_press_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         last_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], btn_n};
         last_q <= sync_q[STAGES-1];
      end
   end

   // One pulse per high-to-low transition of the synchronised button.
   assign press_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/tmr_digit.sv
module tmr_digit #(
   parameter int W     = 4,
   parameter int LIMIT = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         step_i,
   input  logic         up_i,
   output logic [W-1:0] q_o,
   output logic         wrap_o
);
   localparam logic [W-1:0] TOP = W'(LIMIT);

   generate
      if (LIMIT < 1 || LIMIT >= (1 << W)) begin : g_bad_limit
         $error("tmr_digit: LIMIT does not fit the digit width");
      end
   endgenerate

   logic at_top, at_zero;

   assign at_top  = (q_o == TOP);
   assign at_zero = (q_o == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= '0;
      else if (load_i)
         q_o <= TOP;                 // preset value is the digit maximum
      else if (step_i) begin
         if (up_i)
            q_o <= at_top ? '0 : q_o + 1'b1;
         else
            q_o <= at_zero ? TOP : q_o - 1'b1;
      end
   end

   // Carry (up) or borrow (down) into the next digit.
   assign wrap_o = step_i & (up_i ? at_top : at_zero);
endmodule

// File: rtl/tmr_seg7.sv
module tmr_seg7 #(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  tmr_pkg::bcd_t digit_i,
   output tmr_pkg::seg_t seg_o
);
   tmr_pkg::seg_t lit;

   // Segment pattern with 1 = lit, bit 0 = segment a.
   always_comb begin
      case (digit_i)
         4'd0:    lit = 7'h3F;
         4'd1:    lit = 7'h06;
         4'd2:    lit = 7'h5B;
         4'd3:    lit = 7'h4F;
         4'd4:    lit = 7'h66;
         4'd5:    lit = 7'h6D;
         4'd6:    lit = 7'h7D;
         4'd7:    lit = 7'h07;
         4'd8:    lit = 7'h7F;
         4'd9:    lit = 7'h67;
         default: lit = 7'h00;
      endcase
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign seg_o = ~lit;
      end else begin : g_high
         assign seg_o = lit;
      end
   endgenerate
endmodule

// File: rtl/updown_tenths_timer.sv
module updown_tenths_timer
   import tmr_pkg::*;
#(
   parameter int CLK_DIV        = 5_000_000,
   parameter int SYNC_STAGES    = 2,
   parameter bit SEG_ACTIVE_LOW = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       count_up,
   input  logic       preset_n,
   input  logic       run,
   output logic [6:0] seg_tenths,
   output logic [6:0] seg_sec_ones,
   output logic [6:0] seg_sec_tens
);
   generate
      if (SEG_W != 7) begin : g_bad_seg
         $error("updown_tenths_timer: segment width must be 7");
      end
   endgenerate

   logic          tick;
   logic          load;
   logic [DIGITS:0] carry;
   bcd_t          digit_q [DIGITS];
   seg_t          seg_q   [DIGITS];

   tmr_tick_gen #(.DIV(CLK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   tmr_press_sync #(.STAGES(SYNC_STAGES)) u_preset (
      .clk     (clk),
      .rst_n   (rst_n),
      .btn_n   (preset_n),
      .press_o (load)
   );

   assign carry[0] = tick & run;

   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_digit
         tmr_digit #(.W(BCD_W), .LIMIT(digit_limit(i))) u_dig (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .step_i (carry[i]),
            .up_i   (count_up),
            .q_o    (digit_q[i]),
            .wrap_o (carry[i+1])
         );

         tmr_seg7 #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_seg (
            .digit_i (digit_q[i]),
            .seg_o   (seg_q[i])
         );
      end
   endgenerate

   logic unused_top_carry;
   assign unused_top_carry = carry[DIGITS];

   assign seg_tenths   = seg_q[0];
   assign seg_sec_ones = seg_q[1];
   assign seg_sec_tens = seg_q[2];
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
   parameter int DIV = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       run,
   input logic       up,
   input logic       tick,
   input logic       step,
   input logic       load,
   input logic [3:0] d_tenths,
   input logic [3:0] d_ones,
   input logic [3:0] d_tens,
   input logic [6:0] s_tenths,
   input logic [6:0] s_ones,
   input logic [6:0] s_tens
);
   logic at_max, at_min;
   assign at_max = (d_tens == 4'd5) && (d_ones == 4'd9) && (d_tenths == 4'd9);
   assign at_min = (d_tens == 4'd0) && (d_ones == 4'd0) && (d_tenths == 4'd0);

   // R2: the step enable lasts one cycle when the divider ratio exceeds one
   a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      (DIV > 1 && tick) |=> !tick);

   // R3: digits stay inside their radix
   a_r3_digits_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (d_tens <= 4'd5) && (d_ones <= 4'd9) && (d_tenths <= 4'd9));

   // R3: upward wrap from the maximum
   a_r3_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && up && !load && at_max) |=> at_min);

   // R4: downward wrap from zero
   a_r4_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !up && !load && at_min) |=> at_max);

   // R6: one load pulse per press
   a_r6_press_once: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !load);

   // R7: preset always lands on the maximum, step or no step
   a_r7_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (s_tens == 7'h12 && s_ones == 7'h18 && s_tenths == 7'h18));

   // R8: hold keeps digits and segments frozen
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> ($stable({d_tens, d_ones, d_tenths}) && $stable({s_tens, s_ones, s_tenths})));
endmodule

bind updown_tenths_timer tmr_checker #(.DIV(CLK_DIV)) u_tmr_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .up       (count_up),
   .tick     (tick),
   .step     (carry[0]),
   .load     (load),
   .d_tenths (digit_q[0]),
   .d_ones   (digit_q[1]),
   .d_tens   (digit_q[2]),
   .s_tenths (seg_tenths),
   .s_ones   (seg_sec_ones),
   .s_tens   (seg_sec_tens)
);

// File: tb/updown_tenths_timer_test.sv
`timescale 1ns/1ps
module updown_tenths_timer_test;
   localparam int DIV = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic count_up = 1'b1;
   logic preset_n = 1'b1;
   logic run = 1'b0;
   logic [6:0] seg_tenths, seg_sec_ones, seg_sec_tens;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   updown_tenths_timer #(.CLK_DIV(DIV), .SYNC_STAGES(2), .SEG_ACTIVE_LOW(1'b1)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .count_up     (count_up),
      .preset_n     (preset_n),
      .run          (run),
      .seg_tenths   (seg_tenths),
      .seg_sec_ones (seg_sec_ones),
      .seg_sec_tens (seg_sec_tens)
   );

   function automatic logic [6:0] seg_code(input int d);
      case (d)
         0: return 7'h40;  1: return 7'h79;  2: return 7'h24;  3: return 7'h30;
         4: return 7'h19;  5: return 7'h12;  6: return 7'h02;  7: return 7'h78;
         8: return 7'h00;  9: return 7'h18;
         default: return 7'h7F;
      endcase
   endfunction

   function automatic logic [20:0] enc(input int v);
      return {seg_code(v / 100), seg_code((v / 10) % 10), seg_code(v % 10)};
   endfunction

   // Behavioural reference: count in tenths 0..599, free divider, press history.
   int mval = 0;
   int mdcnt = 0;
   int h1 = 1, h2 = 1, h3 = 1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mval = 0; mdcnt = 0; h1 = 1; h2 = 1; h3 = 1;
      end else begin
         bit ld, tk;
         ld = (h2 == 0) && (h3 == 1);
         tk = (mdcnt == DIV - 1);
         mdcnt = tk ? 0 : mdcnt + 1;
         if (ld)
            mval = 599;
         else if (tk && run)
            mval = count_up ? (mval + 1) % 600 : (mval + 599) % 600;
         h3 = h2; h2 = h1; h1 = int'(preset_n);
      end
   end

   function automatic logic [20:0] observed();
      return {seg_sec_tens, seg_sec_ones, seg_tenths};
   endfunction

   // Every-cycle comparison with the reference model.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (observed() !== enc(mval)) begin
            failures++;
            $display("FAIL R9 model compare: got %h expected %h (value %0d)", observed(), enc(mval), mval);
         end
      end
   end

   task automatic chk(input string tag, input int expv);
      checks++;
      if (observed() !== enc(expv)) begin
         failures++;
         $display("FAIL %s: got %h expected %h (value %0d)", tag, observed(), enc(expv), expv);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      edges(3);
      chk("R1 in reset", 0);
      run = 1'b1;
      count_up = 1'b1;
      rst_n = 1'b1;
      edges(3);
      chk("R2 before first step", 0);
      edges(1);
      chk("R2 first step", 1);
      for (int i = 2; i <= 9; i++) begin
         edges(DIV);
         chk("R9 tenths codes", i);
      end
      edges(DIV * 90);
      chk("R3 at 09.9", 99);
      edges(DIV);
      chk("R3 carry to 10.0", 100);
      edges(DIV * 499);
      chk("R3 at 59.9", 599);
      edges(DIV);
      chk("R3 wrap to 00.0", 0);
      // change direction between steps
      edges(2);
      count_up = 1'b0;
      edges(2);
      chk("R4 wrap to 59.9", 599);
      chk("R5 down change", 599);
      edges(DIV);
      chk("R4 down step", 598);
      edges(DIV * 498);
      chk("R4 at 10.0", 100);
      edges(DIV);
      chk("R4 borrow to 09.9", 99);
      edges(2);
      count_up = 1'b1;
      edges(2);
      chk("R5 up change", 100);
      // preset press away from a step edge
      preset_n = 1'b0;
      edges(2);
      chk("R6 not yet loaded", 100);
      edges(1);
      chk("R6 loaded", 599);
      edges(1);
      chk("R6 held button counts on", 0);
      edges(8);
      chk("R6 no reload", 2);
      preset_n = 1'b1;
      // preset load on the same edge as a step
      edges(1);
      preset_n = 1'b0;
      edges(3);
      chk("R7 preset over step", 599);
      preset_n = 1'b1;
      edges(DIV);
      chk("R7 resumes after preset", 0);
      // hold
      run = 1'b0;
      edges(20);
      chk("R8 held", 0);
      preset_n = 1'b0;
      edges(3);
      chk("R8 preset in hold", 599);
      preset_n = 1'b1;
      edges(5);
      chk("R8 still held", 599);
      run = 1'b1;
      edges(DIV);
      chk("R8 resume", 0);
      edges(DIV * 7);
      chk("R8 running again", 7);
      // asynchronous reset mid-run
      rst_n = 1'b0;
      #1;
      chk("R1 async reset", 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule